// File: doc/BRIEF.md
# Decomposed Multi-Field Rule Classifier

This block classifies an already-parsed packet header against a set of numbered rules without a single wide ternary table. Every header field gets its own small table. Five engines run on the same header in the same cycle: a prefix table for the source address, a prefix table for the destination address, a range table for the destination L4 port, a range table for the packet length, and a masked-compare table fed by a window of bytes taken from the payload at a programmable byte offset. Each table entry names the rules it serves through a rule-membership bitmask. An engine returns the OR of the bitmasks of all its matching entries, plus a per-engine wildcard vector for rules that do not care about that field.

The five rule vectors are ANDed. The lowest-numbered surviving rule wins and its action byte is returned. A rule that needs three prefixes and four port ranges therefore costs seven entries, not twelve. Headers arrive on a valid/ready input at one per cycle, and results come out a fixed two cycles later. Tables, wildcards, the payload offset, the per-rule actions and the default action are loaded through a simple write-only register port.

Top module: `cls_multifield_top`

## Requirements
- R1: While reset is low, hdr_ready and res_valid are 0. Reset empties every table bitmask, every wildcard vector, every action and the default action, so a lookup right after reset misses and returns action 0.
- R2: A prefix entry (word 0 value, word 1 length, word 2 rule mask) matches when the top `length` bits of its address equal those of the value. Length 0 matches any address and length 32 needs an exact match. The source and destination tables are independent.
- R3: A port-range entry (word 0 low, word 1 high, word 2 rule mask) matches when low <= hdr_dport <= high, both ends inclusive. An entry with low > high never matches.
- R4: A length-range entry uses the same layout and matches when low <= hdr_len <= high, both ends inclusive.
- R5: The payload key is four bytes, starting at the control offset. Payload byte i is hdr_payload[8i+7:8i], and the byte at the offset lands in key bits [31:24]. Key bytes past the last payload byte read as 0. An entry (word 0 pattern, word 1 compare mask, word 2 rule mask) matches when the key and the pattern agree on every bit set in the compare mask.
- R6: A rule survives only if each of the five engine vectors has its bit set. An engine vector is the OR of its matching entries' masks with that engine's wildcard. Among survivors, the lowest-numbered rule is reported with res_hit=1 and its programmed action.
- R7: With no survivor, res_hit=0, res_rule=0 and res_action equals the default action.
- R8: hdr_ready is 1 from the first cycle after reset is released. A header accepted in cycle t gives res_valid=1 in cycle t+2 and in no other cycle. Back-to-back headers give back-to-back results.
- R9: Field conditions of one rule combine as a cross product without extra entries. A rule with 3 destination prefixes and 4 port ranges uses 3+4 entries and hits on all 12 combinations.
- R10: cfg_addr[10:8] selects the table: 0 src prefix, 1 dst prefix, 2 port, 3 length, 4 payload, 5 control, 6 action. cfg_addr[7:3] is the entry index and cfg_addr[2:0] the word. In control, words 0..4 hold the wildcards for tables 0..4, word 5 holds the payload offset and word 6 the default action. In the action table the index is the rule and word 0 holds the action. Writes to a match-table index of 16 or more, or to table 7, change nothing. A write affects headers presented from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header accepted this cycle when valid |
| hdr_src | input | 32 | Source address |
| hdr_dst | input | 32 | Destination address |
| hdr_dport | input | 16 | Destination L4 port |
| hdr_len | input | 16 | Packet length |
| hdr_payload | input | 128 | First 16 payload bytes, byte 0 in bits [7:0] |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 11 | Table, entry index, word |
| cfg_wdata | input | 32 | Write data |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | A rule matched |
| res_rule | output | 5 | Winning rule number, 0 on miss |
| res_action | output | 8 | Winning rule's action, or the default action |

## Verification
A corrupted table entry or wildcard shows at the ports as a wrong hit or miss, or as the wrong winning rule, on the first header whose field falls on the damaged entry. That result appears exactly two cycles after the header. An error in the stage register or the priority encoder shows up on the very next result, as a wrong rule number or as an action that does not belong to that rule. Timing errors show as res_valid in a cycle other than two after acceptance. The directed cases therefore place keys on both edges of each range and prefix, on offsets that run past the payload end, and on rules that overlap.

// File: rtl/cls_pkg.sv
// Package: shared constants and the configuration address layout for the
// decomposed rule classifier. Assumes at most 32 rules and 32 entries per table.
package cls_pkg;
    localparam int N_ENG = 5;

    // Table select codes; codes 0..4 also name the wildcard word of each engine
    localparam logic [2:0] TBL_SRC  = 3'd0;
    localparam logic [2:0] TBL_DST  = 3'd1;
    localparam logic [2:0] TBL_PORT = 3'd2;
    localparam logic [2:0] TBL_LEN  = 3'd3;
    localparam logic [2:0] TBL_PAY  = 3'd4;
    localparam logic [2:0] TBL_CTL  = 3'd5;
    localparam logic [2:0] TBL_ACT  = 3'd6;

    // Entry word codes
    localparam logic [2:0] W_A    = 3'd0;  // value, low bound or pattern
    localparam logic [2:0] W_B    = 3'd1;  // prefix length, high bound or compare mask
    localparam logic [2:0] W_MASK = 3'd2;  // rule-membership bitmask

    // Control word codes
    localparam logic [2:0] W_OFF  = 3'd5;
    localparam logic [2:0] W_DFLT = 3'd6;

    typedef struct packed {
        logic [2:0] tbl;
        logic [4:0] idx;
        logic [2:0] word;
    } cfg_addr_t;
endpackage

// File: rtl/cls_prefix_eng.sv
// Prefix engine: N_ENT entries of (value, prefix length, rule mask).
// An entry matches when the leading plen bits of key equal those of value;
// plen 0 matches everything, plen >= KEY_W compares all bits.
// Output is the OR of rule masks of all matching entries (combinational).
module cls_prefix_eng
    import cls_pkg::*;
#(
    parameter int N_RULES = 32,
    parameter int N_ENT   = 16,
    parameter int KEY_W   = 32,
    localparam int IDX_W  = $clog2(N_ENT),
    localparam int PLEN_W = $clog2(KEY_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [2:0]         wr_word,
    input  logic [31:0]        wr_data,
    input  logic [KEY_W-1:0]   key,
    output logic [N_RULES-1:0] hits
);
    logic [N_ENT-1:0][KEY_W-1:0]   val_q;
    logic [N_ENT-1:0][PLEN_W-1:0]  plen_q;
    logic [N_ENT-1:0][N_RULES-1:0] rmask_q;

    // Table storage: one word written per strobe, all masks cleared in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q   <= '0;
            plen_q  <= '0;
            rmask_q <= '0;
        end else if (wr_en) begin
            case (wr_word)
                W_A:     val_q[wr_idx]   <= wr_data[KEY_W-1:0];
                W_B:     plen_q[wr_idx]  <= wr_data[PLEN_W-1:0];
                W_MASK:  rmask_q[wr_idx] <= wr_data[N_RULES-1:0];
                default: ;
            endcase
        end
    end

    // Match all entries in parallel and merge their rule masks
    always_comb begin
        logic [KEY_W-1:0] pmask;
        hits = '0;
        for (int e = 0; e < N_ENT; e++) begin
            pmask = ~({KEY_W{1'b1}} >> plen_q[e]);
            if (((key ^ val_q[e]) & pmask) == '0)
                hits = hits | rmask_q[e];
        end
    end

    // R10: a mask write lands in the addressed entry
    a_r10_pfx_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word == W_MASK) |=>
            rmask_q[$past(wr_idx)] == $past(wr_data[N_RULES-1:0]));
endmodule

// File: rtl/cls_range_eng.sv
// Range engine: N_ENT entries of (low, high, rule mask); inclusive bounds.
// Entries with low > high never match. Output is the OR of matching masks.
module cls_range_eng
    import cls_pkg::*;
#(
    parameter int N_RULES = 32,
    parameter int N_ENT   = 16,
    parameter int KEY_W   = 16,
    localparam int IDX_W  = $clog2(N_ENT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [2:0]         wr_word,
    input  logic [31:0]        wr_data,
    input  logic [KEY_W-1:0]   key,
    output logic [N_RULES-1:0] hits
);
    logic [N_ENT-1:0][KEY_W-1:0]   lo_q;
    logic [N_ENT-1:0][KEY_W-1:0]   hi_q;
    logic [N_ENT-1:0][N_RULES-1:0] rmask_q;

    // Table storage: bounds and masks, cleared in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            rmask_q <= '0;
        end else if (wr_en) begin
            case (wr_word)
                W_A:     lo_q[wr_idx]    <= wr_data[KEY_W-1:0];
                W_B:     hi_q[wr_idx]    <= wr_data[KEY_W-1:0];
                W_MASK:  rmask_q[wr_idx] <= wr_data[N_RULES-1:0];
                default: ;
            endcase
        end
    end

    // Compare key against every range and merge masks of those containing it
    always_comb begin
        hits = '0;
        for (int e = 0; e < N_ENT; e++) begin
            if (key >= lo_q[e] && key <= hi_q[e])
                hits = hits | rmask_q[e];
        end
    end

    // R3: a low-bound write lands in the addressed entry
    a_r3_range_low_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word == W_A) |=>
            lo_q[$past(wr_idx)] == $past(wr_data[KEY_W-1:0]));
endmodule

// File: rtl/cls_payload_eng.sv
// Payload engine: extracts KEY_BYTES bytes starting at a programmable byte
// offset (first byte most significant, bytes past the end read 0) and
// compares the window with N_ENT (pattern, compare mask, rule mask) entries.
module cls_payload_eng
    import cls_pkg::*;
#(
    parameter int N_RULES   = 32,
    parameter int N_ENT     = 16,
    parameter int PAY_BYTES = 16,
    parameter int KEY_BYTES = 4,
    localparam int IDX_W    = $clog2(N_ENT),
    localparam int OFF_W    = $clog2(PAY_BYTES),
    localparam int PAT_W    = KEY_BYTES * 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [2:0]             wr_word,
    input  logic [31:0]            wr_data,
    input  logic                   off_we,
    input  logic [PAY_BYTES*8-1:0] payload,
    output logic [N_RULES-1:0]     hits
);
    logic [N_ENT-1:0][PAT_W-1:0]   pat_q;
    logic [N_ENT-1:0][PAT_W-1:0]   cmp_q;
    logic [N_ENT-1:0][N_RULES-1:0] rmask_q;
    logic [OFF_W-1:0]              off_q;
    logic [PAT_W-1:0]              win;

    // Table storage and window offset, cleared in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q   <= '0;
            cmp_q   <= '0;
            rmask_q <= '0;
            off_q   <= '0;
        end else begin
            if (off_we)
                off_q <= wr_data[OFF_W-1:0];
            if (wr_en) begin
                case (wr_word)
                    W_A:     pat_q[wr_idx]   <= wr_data[PAT_W-1:0];
                    W_B:     cmp_q[wr_idx]   <= wr_data[PAT_W-1:0];
                    W_MASK:  rmask_q[wr_idx] <= wr_data[N_RULES-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Byte-window extractor at the programmed offset
    always_comb begin
        int pos;
        win = '0;
        for (int j = 0; j < KEY_BYTES; j++) begin
            pos = int'(off_q) + j;
            if (pos < PAY_BYTES)
                win[(KEY_BYTES-1-j)*8 +: 8] = payload[pos*8 +: 8];
        end
    end

    // Masked compare of the window against every entry
    always_comb begin
        hits = '0;
        for (int e = 0; e < N_ENT; e++) begin
            if (((win ^ pat_q[e]) & cmp_q[e]) == '0)
                hits = hits | rmask_q[e];
        end
    end

    // R5: window bytes that fall past the payload end are zero
    for (genvar j = 0; j < KEY_BYTES; j++) begin : g_tail
        a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
            ((int'(off_q) + j) >= PAY_BYTES) |-> (win[(KEY_BYTES-1-j)*8 +: 8] == 8'h00));
    end
endmodule

// File: rtl/cls_rule_select.sv
// Rule selector: ANDs the per-engine rule vectors and picks the lowest set
// bit. Purely combinational; the caller registers the result.
module cls_rule_select #(
    parameter int N_RULES = 32,
    parameter int N_ENG   = 5,
    localparam int RULE_W = $clog2(N_RULES)
) (
    input  logic [N_ENG-1:0][N_RULES-1:0] vecs,
    output logic [N_RULES-1:0]            all_vec,
    output logic                          hit,
    output logic [RULE_W-1:0]             idx
);
    // Intersect all engine vectors
    always_comb begin
        all_vec = '1;
        for (int e = 0; e < N_ENG; e++)
            all_vec = all_vec & vecs[e];
    end

    // Lowest-numbered survivor wins
    always_comb begin
        hit = |all_vec;
        idx = '0;
        for (int r = N_RULES - 1; r >= 0; r--)
            if (all_vec[r])
                idx = RULE_W'(r);
    end
endmodule

// File: rtl/cls_multifield_top.sv
// Decomposed multi-field classifier top. Stage 1 registers the five engine
// vectors (with wildcards merged); stage 2 registers the winning rule and
// action. Accepts one header per cycle; result two cycles after acceptance.
// Assumes N_RULES <= 32 and N_ENT <= 32 to fit the write port fields.
module cls_multifield_top
    import cls_pkg::*;
#(
    parameter int N_RULES   = 32,
    parameter int N_ENT     = 16,
    parameter int ADDR_W    = 32,
    parameter int RNG_W     = 16,
    parameter int PAY_BYTES = 16,
    parameter int KEY_BYTES = 4,
    parameter int ACT_W     = 8,
    localparam int RULE_W   = $clog2(N_RULES),
    localparam int ENT_W    = $clog2(N_ENT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hdr_valid,
    output logic                   hdr_ready,
    input  logic [ADDR_W-1:0]      hdr_src,
    input  logic [ADDR_W-1:0]      hdr_dst,
    input  logic [RNG_W-1:0]       hdr_dport,
    input  logic [RNG_W-1:0]       hdr_len,
    input  logic [PAY_BYTES*8-1:0] hdr_payload,
    input  logic                   cfg_we,
    input  logic [10:0]            cfg_addr,
    input  logic [31:0]            cfg_wdata,
    output logic                   res_valid,
    output logic                   res_hit,
    output logic [RULE_W-1:0]      res_rule,
    output logic [ACT_W-1:0]       res_action
);
    cfg_addr_t                     ca;
    logic                          idx_ok;
    logic                          accept;
    logic                          ready_q;
    logic [N_ENG-1:0][N_RULES-1:0] raw_vec;
    logic [N_ENG-1:0][N_RULES-1:0] wild_q;
    logic [N_ENG-1:0][N_RULES-1:0] s1_vec;
    logic                          s1_valid;
    logic [N_RULES-1:0][ACT_W-1:0] act_q;
    logic [ACT_W-1:0]              dflt_q;
    logic [N_RULES-1:0]            sel_all;
    logic                          sel_hit;
    logic [RULE_W-1:0]             sel_idx;
    logic [1:0][ADDR_W-1:0]        pfx_key;
    logic [1:0][RNG_W-1:0]         rng_key;

    assign ca        = cfg_addr_t'(cfg_addr);
    assign idx_ok    = int'(ca.idx) < N_ENT;
    assign accept    = hdr_valid && ready_q;
    assign hdr_ready = ready_q;
    assign pfx_key   = {hdr_dst, hdr_src};
    assign rng_key   = {hdr_len, hdr_dport};

    // Source and destination prefix engines
    for (genvar g = 0; g < 2; g++) begin : g_pfx
        cls_prefix_eng #(.N_RULES(N_RULES), .N_ENT(N_ENT), .KEY_W(ADDR_W)) u_pfx (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && idx_ok && ca.tbl == (TBL_SRC + 3'(g))),
            .wr_idx  (ca.idx[ENT_W-1:0]),
            .wr_word (ca.word),
            .wr_data (cfg_wdata),
            .key     (pfx_key[g]),
            .hits    (raw_vec[g])
        );
    end

    // Port and length range engines
    for (genvar g = 0; g < 2; g++) begin : g_rng
        cls_range_eng #(.N_RULES(N_RULES), .N_ENT(N_ENT), .KEY_W(RNG_W)) u_rng (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && idx_ok && ca.tbl == (TBL_PORT + 3'(g))),
            .wr_idx  (ca.idx[ENT_W-1:0]),
            .wr_word (ca.word),
            .wr_data (cfg_wdata),
            .key     (rng_key[g]),
            .hits    (raw_vec[2+g])
        );
    end

    // Payload window engine
    cls_payload_eng #(
        .N_RULES(N_RULES), .N_ENT(N_ENT), .PAY_BYTES(PAY_BYTES), .KEY_BYTES(KEY_BYTES)
    ) u_pay (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we && idx_ok && ca.tbl == TBL_PAY),
        .wr_idx  (ca.idx[ENT_W-1:0]),
        .wr_word (ca.word),
        .wr_data (cfg_wdata),
        .off_we  (cfg_we && ca.tbl == TBL_CTL && ca.word == W_OFF),
        .payload (hdr_payload),
        .hits    (raw_vec[4])
    );

    // Control registers: wildcards, default action, per-rule actions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wild_q <= '0;
            dflt_q <= '0;
            act_q  <= '0;
        end else if (cfg_we) begin
            if (ca.tbl == TBL_CTL && int'(ca.word) < N_ENG)
                wild_q[ca.word] <= cfg_wdata[N_RULES-1:0];
            if (ca.tbl == TBL_CTL && ca.word == W_DFLT)
                dflt_q <= cfg_wdata[ACT_W-1:0];
            if (ca.tbl == TBL_ACT && ca.word == W_A && int'(ca.idx) < N_RULES)
                act_q[ca.idx[RULE_W-1:0]] <= cfg_wdata[ACT_W-1:0];
        end
    end

    // Stage 1: capture engine vectors merged with wildcards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q  <= 1'b0;
            s1_valid <= 1'b0;
            s1_vec   <= '0;
        end else begin
            ready_q  <= 1'b1;
            s1_valid <= accept;
            for (int e = 0; e < N_ENG; e++)
                s1_vec[e] <= raw_vec[e] | wild_q[e];
        end
    end

    cls_rule_select #(.N_RULES(N_RULES), .N_ENG(N_ENG)) u_sel (
        .vecs    (s1_vec),
        .all_vec (sel_all),
        .hit     (sel_hit),
        .idx     (sel_idx)
    );

    // Stage 2: register winner and its action, or the default on a miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_rule   <= '0;
            res_action <= '0;
        end else begin
            res_valid  <= s1_valid;
            res_hit    <= s1_valid && sel_hit;
            res_rule   <= (s1_valid && sel_hit) ? sel_idx : '0;
            res_action <= (s1_valid && sel_hit) ? act_q[sel_idx] : dflt_q;
        end
    end

    // One-hot view of the reported rule, used only by the check below
    logic [N_RULES-1:0] res_bit;
    assign res_bit = {{(N_RULES-1){1'b0}}, 1'b1} << res_rule;

    // R8: result appears exactly two cycles after acceptance
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(hdr_valid && hdr_ready, 2));

    // R8: ready from the first cycle after reset release
    a_r8_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> hdr_ready);

    // R7: a miss reports rule 0 and the default action
    a_r7_miss_default: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_rule == '0 && res_action == $past(dflt_q)));

    // R6: the reported rule survived and no lower rule did
    a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (($past(sel_all) & ((res_bit << 1) - 1'b1)) == res_bit));
endmodule

// File: tb/cls_multifield_top_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module cls_multifield_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hdr_valid = 1'b0;
    logic         hdr_ready;
    logic [31:0]  hdr_src = '0;
    logic [31:0]  hdr_dst = '0;
    logic [15:0]  hdr_dport = '0;
    logic [15:0]  hdr_len = '0;
    logic [127:0] hdr_payload = '0;
    logic         cfg_we = 1'b0;
    logic [10:0]  cfg_addr = '0;
    logic [31:0]  cfg_wdata = '0;
    logic         res_valid;
    logic         res_hit;
    logic [4:0]   res_rule;
    logic [7:0]   res_action;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cls_multifield_top dut_i (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_src(hdr_src), .hdr_dst(hdr_dst), .hdr_dport(hdr_dport), .hdr_len(hdr_len),
        .hdr_payload(hdr_payload), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .res_valid(res_valid), .res_hit(res_hit),
        .res_rule(res_rule), .res_action(res_action)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // All tasks begin and end at a falling edge
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(hdr_ready, 0, "R1", "ready in reset");
        chk(res_valid, 0, "R1", "valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(hdr_ready, 1, "R8", "ready after reset");
    endtask

    task automatic cfg(input int tbl, input int idx, input int word, input logic [31:0] d);
        cfg_we = 1'b1;
        cfg_addr = {3'(tbl), 5'(idx), 3'(word)};
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(input logic [31:0] s, input logic [31:0] d, input logic [15:0] p,
                         input logic [15:0] l, input logic [127:0] pl);
        hdr_valid = 1'b1;
        hdr_src = s; hdr_dst = d; hdr_dport = p; hdr_len = l; hdr_payload = pl;
    endtask

    task automatic expect_res(input logic eh, input logic [4:0] er, input logic [7:0] ea,
                              input string tag);
        chk(res_valid, 1, tag, "res_valid");
        chk(res_hit, eh, tag, "res_hit");
        chk(res_rule, er, tag, "res_rule");
        chk(res_action, ea, tag, "res_action");
    endtask

    task automatic look(input logic [31:0] s, input logic [31:0] d, input logic [15:0] p,
                        input logic [15:0] l, input logic [127:0] pl,
                        input logic eh, input logic [4:0] er, input logic [7:0] ea,
                        input string tag);
        drive(s, d, p, l, pl);
        @(negedge clk);
        hdr_valid = 1'b0;
        chk(res_valid, 0, tag, "res_valid one cycle after");
        @(negedge clk);
        expect_res(eh, er, ea, tag);
    endtask

    function automatic logic [127:0] fill(input logic [7:0] b);
        return {16{b}};
    endfunction

    // R2: prefix matching on source and destination tables
    task automatic t_prefix();
        do_reset();
        cfg(6, 3, 0, 32'h33);
        cfg(0, 0, 0, 32'h0A000000); cfg(0, 0, 1, 8); cfg(0, 0, 2, 32'h8);
        for (int w = 1; w < 5; w++) cfg(5, 0, w, 32'h8);
        look(32'h0A010203, 0, 0, 0, 0, 1, 3, 8'h33, "R2");
        look(32'h0B000001, 0, 0, 0, 0, 0, 0, 8'h00, "R2");
        cfg(1, 2, 0, 32'hC0A80100); cfg(1, 2, 1, 24); cfg(1, 2, 2, 32'h8);
        cfg(5, 0, 1, 0);
        look(32'h0A000001, 32'hC0A801FF, 0, 0, 0, 1, 3, 8'h33, "R2");
        look(32'h0A000001, 32'hC0A80200, 0, 0, 0, 0, 0, 8'h00, "R2");
        cfg(1, 3, 0, 32'h01020304); cfg(1, 3, 1, 32); cfg(1, 3, 2, 32'h8);
        look(32'h0A000001, 32'h01020304, 0, 0, 0, 1, 3, 8'h33, "R2");
        look(32'h0A000001, 32'h01020305, 0, 0, 0, 0, 0, 8'h00, "R2");
        cfg(0, 1, 1, 0); cfg(0, 1, 2, 32'h8);
        look(32'hFFFFFFFF, 32'h01020304, 0, 0, 0, 1, 3, 8'h33, "R2");
    endtask

    // R3, R4, R6, R7: inclusive ranges, intersection, priority, default
    task automatic t_ranges();
        do_reset();
        cfg(6, 0, 0, 32'hA0); cfg(6, 2, 0, 32'hA2);
        cfg(2, 0, 0, 1000); cfg(2, 0, 1, 2000); cfg(2, 0, 2, 32'h1);
        cfg(3, 0, 0, 64);   cfg(3, 0, 1, 128);  cfg(3, 0, 2, 32'h4);
        cfg(5, 0, 0, 32'h5); cfg(5, 0, 1, 32'h5); cfg(5, 0, 2, 32'h4);
        cfg(5, 0, 3, 32'h1); cfg(5, 0, 4, 32'h5);
        look(0, 0, 999,  500, 0, 0, 0, 8'h00, "R3");
        look(0, 0, 1000, 500, 0, 1, 0, 8'hA0, "R3");
        look(0, 0, 2000, 500, 0, 1, 0, 8'hA0, "R3");
        look(0, 0, 2001, 500, 0, 0, 0, 8'h00, "R3");
        look(0, 0, 1500, 100, 0, 1, 0, 8'hA0, "R6");
        look(0, 0, 5, 64,  0, 1, 2, 8'hA2, "R4");
        look(0, 0, 5, 128, 0, 1, 2, 8'hA2, "R4");
        look(0, 0, 5, 129, 0, 0, 0, 8'h00, "R4");
        look(0, 0, 5, 63,  0, 0, 0, 8'h00, "R4");
        cfg(2, 1, 0, 3000); cfg(2, 1, 1, 2500); cfg(2, 1, 2, 32'h1);
        cfg(5, 0, 6, 32'hEE);
        look(0, 0, 2700, 500, 0, 0, 0, 8'hEE, "R3");
        look(0, 0, 5, 129, 0, 0, 0, 8'hEE, "R7");
    endtask

    // R5: payload window at an offset, tail zero fill, masked compare
    task automatic t_payload();
        logic [127:0] pl;
        do_reset();
        cfg(6, 4, 0, 32'h44); cfg(6, 6, 0, 32'h66);
        for (int w = 0; w < 4; w++) cfg(5, 0, w, 32'h50);
        cfg(5, 0, 5, 2);
        cfg(4, 0, 0, 32'hDEADBEEF); cfg(4, 0, 1, 32'hFFFFFFFF); cfg(4, 0, 2, 32'h10);
        pl = fill(8'h55);
        pl[23:16] = 8'hDE; pl[31:24] = 8'hAD; pl[39:32] = 8'hBE; pl[47:40] = 8'hEF;
        look(0, 0, 0, 0, pl, 1, 4, 8'h44, "R5");
        pl[47:40] = 8'hEE;
        look(0, 0, 0, 0, pl, 0, 0, 8'h00, "R5");
        cfg(5, 0, 5, 14);
        cfg(4, 1, 0, 32'hABCD0000); cfg(4, 1, 1, 32'hFFFFFFFF); cfg(4, 1, 2, 32'h10);
        pl = fill(8'h55);
        pl[119:112] = 8'hAB; pl[127:120] = 8'hCD;
        look(0, 0, 0, 0, pl, 1, 4, 8'h44, "R5");
        cfg(4, 2, 0, 32'h11000000); cfg(4, 2, 1, 32'hFF000000); cfg(4, 2, 2, 32'h40);
        cfg(5, 0, 5, 0);
        pl = fill(8'h55); pl[7:0] = 8'h11;
        look(0, 0, 0, 0, pl, 1, 6, 8'h66, "R5");
        pl[7:0] = 8'h12;
        look(0, 0, 0, 0, pl, 0, 0, 8'h00, "R5");
    endtask

    // R9, R8: additive storage cross product and back-to-back timing
    task automatic t_cross();
        logic [15:0] ports [4] = '{16'd80, 16'd443, 16'd8050, 16'd22};
        do_reset();
        cfg(6, 7, 0, 32'h77);
        for (int i = 0; i < 3; i++) begin
            cfg(1, i, 0, (32'(10 * (i + 1))) << 24); cfg(1, i, 1, 8); cfg(1, i, 2, 32'h80);
        end
        cfg(2, 0, 0, 80);   cfg(2, 0, 1, 80);   cfg(2, 0, 2, 32'h80);
        cfg(2, 1, 0, 443);  cfg(2, 1, 1, 443);  cfg(2, 1, 2, 32'h80);
        cfg(2, 2, 0, 8000); cfg(2, 2, 1, 8099); cfg(2, 2, 2, 32'h80);
        cfg(2, 3, 0, 22);   cfg(2, 3, 1, 22);   cfg(2, 3, 2, 32'h80);
        cfg(5, 0, 0, 32'h80); cfg(5, 0, 3, 32'h80); cfg(5, 0, 4, 32'h80);
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 4; j++)
                look(0, ((32'(10 * (i + 1))) << 24) | 32'h00010203, ports[j], 0, 0,
                     1, 7, 8'h77, "R9");
        look(0, 32'h28000001, 80, 0, 0, 0, 0, 8'h00, "R9");
        look(0, 32'h0A000001, 81, 0, 0, 0, 0, 8'h00, "R9");
        drive(0, 32'h0A000001, 443, 0, 0);
        @(negedge clk);
        drive(0, 32'h0A000001, 444, 0, 0);
        @(negedge clk);
        expect_res(1, 7, 8'h77, "R8");
        drive(0, 32'h1E000001, 22, 0, 0);
        @(negedge clk);
        hdr_valid = 1'b0;
        expect_res(0, 0, 8'h00, "R8");
        @(negedge clk);
        expect_res(1, 7, 8'h77, "R8");
        @(negedge clk);
        chk(res_valid, 0, "R8", "res_valid after burst");
    endtask

    // R10, R1: ignored writes, next-cycle effect, reset clears tables
    task automatic t_cfg();
        do_reset();
        cfg(6, 0, 0, 32'h5A);
        cfg(5, 0, 0, 1); cfg(5, 0, 1, 1); cfg(5, 0, 3, 1); cfg(5, 0, 4, 1);
        cfg(2, 16, 0, 0); cfg(2, 16, 1, 32'hFFFF); cfg(2, 16, 2, 1);
        look(0, 0, 100, 0, 0, 0, 0, 8'h00, "R10");
        cfg(7, 0, 2, 1);
        look(0, 0, 100, 0, 0, 0, 0, 8'h00, "R10");
        cfg(2, 0, 0, 0); cfg(2, 0, 1, 32'hFFFF); cfg(2, 0, 2, 1);
        look(0, 0, 100, 0, 0, 1, 0, 8'h5A, "R10");
        do_reset();
        look(0, 0, 100, 0, 0, 0, 0, 8'h00, "R1");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_prefix();
        t_ranges();
        t_payload();
        t_cross();
        t_cfg();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule